// File: doc/BRIEF.md
# Sidepanel and Blanking Inserter

This block sits in a 4:4:4 digital video path running on the pixel clock. It receives a 10-bit unsigned luminance sample and two 8-bit two's-complement chrominance samples every clock, together with a line reference pulse and a frame reference pulse. From the line reference it keeps a pixel position within the line, and from both references it keeps a line number within the frame. Three windows are derived from these counts: a horizontal sidepanel window, a horizontal blanking window and a vertical blanking window.

Inside the blanking windows the video is forced to black with neutral colour. Inside the sidepanel window the luminance and the upper chroma nibbles are replaced by programmable values, so the panel can carry a flat grey or tinted fill. Blanking wins over the panel. All windows are programmed through a small parallel write port; the sidepanel edges use a coarse step of four pixels plus a fine offset of zero to three pixels.

A tracking state machine gates the windows until the references have been seen: `TRK_IDLE` (no reference yet), `TRK_HLOCK` (line reference seen), `TRK_VLOCK` (frame reference seen) and `TRK_FULL` (both seen). Its transitions are IDLE to HLOCK on a line edge, IDLE to VLOCK on a frame edge, IDLE to FULL on both in the same clock, HLOCK to FULL on a frame edge and VLOCK to FULL on a line edge; FULL holds until reset. The output mixer picks one of three selections each clock: `SEL_PASS`, `SEL_PANEL` or `SEL_BLANK`.

Top module: `panel_blank_inserter`

## Requirements
- R1: Output video equals the input video delayed by exactly one clock whenever no window applies; during reset the outputs are zero.
- R2: A rising edge of `h_ref` (high now, low on the previous clock) gives the current pixel position 0; each later clock adds one, and the position stops at all ones (4095 by default) instead of wrapping.
- R3: Sidepanel start and stop positions are coarse×4 + fine, with the coarse value in write bits [9:0] and the fine value in write bits [13:12].
- R4: Inside the sidepanel window the output luma is the programmed panel luma, and the upper four bits of each chroma output are the programmed nibbles while the lower four bits are zero.
- R5: Blanking outputs luma code 64 and chroma 0 on both channels.
- R6: Blanking applies when the horizontal part or the vertical part is active.
- R7: The horizontal blanking part covers pixel positions from its set position up to but not including its reset position.
- R8: A rising edge of `v_ref` gives line 0; each rising edge of `h_ref` adds one to the line (saturating at all ones); the frame edge wins when both occur in the same clock. The vertical blanking part covers lines from its set line up to but not including its reset line.
- R9: A window whose start equals or exceeds its stop is never active.
- R10: When blanking and the sidepanel are both active, the blanking values are output.
- R11: Horizontal windows act only after the first `h_ref` edge since reset, and the vertical window only after the first `v_ref` edge; before that the video passes unchanged.
- R12: Write address map (`wr_en` high for one clock, effective from the next clock): 0 panel start, 1 panel stop, 2 horizontal blank set [11:0], 3 horizontal blank reset [11:0], 4 vertical blank set line [10:0], 5 vertical blank reset line [10:0], 6 panel luma [9:0], 7 panel chroma with the U nibble in [3:0] and the V nibble in [7:4]; all registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 14 | Register write data |
| h_ref | input | 1 | Line reference pulse |
| v_ref | input | 1 | Frame reference pulse |
| y_in | input | 10 | Input luma, unsigned |
| u_in | input | 8 | Input U chroma, two's complement |
| v_in | input | 8 | Input V chroma, two's complement |
| y_out | output | 10 | Output luma |
| u_out | output | 8 | Output U chroma |
| v_out | output | 8 | Output V chroma |

## Verification
Every video result is due exactly one clock after its input sample: the position, line number and window decisions for a sample are formed in the same clock as that sample and only the mixed result is registered. The bench drives each sample and its reference levels on a falling edge, keeps its own position, line and lock model updated with that sample, and compares the outputs on the next falling edge, after the single register stage. Register writes are issued before any reference edge so that they take effect before the windows are enabled.

// File: rtl/pbi_pkg.sv
`timescale 1ns/1ps
package pbi_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_PAN_START = 3'd0,
        REG_PAN_STOP  = 3'd1,
        REG_HB_SET    = 3'd2,
        REG_HB_RST    = 3'd3,
        REG_VB_SET    = 3'd4,
        REG_VB_RST    = 3'd5,
        REG_PAN_LUMA  = 3'd6,
        REG_PAN_CHROM = 3'd7
    } reg_addr_t;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_HLOCK = 2'd1,
        TRK_VLOCK = 2'd2,
        TRK_FULL  = 2'd3
    } trk_state_t;

    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_PANEL = 2'd1,
        SEL_BLANK = 2'd2
    } mix_sel_t;

endpackage

// File: rtl/pbi_regs.sv
`timescale 1ns/1ps
module pbi_regs
    import pbi_pkg::*;
#(
    parameter int HPOS_W = 12,
    parameter int LINE_W = 11,
    parameter int Y_W    = 10,
    parameter int NIB_W  = 4,
    parameter int DW     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [HPOS_W-1:0] pan_start,
    output logic [HPOS_W-1:0] pan_stop,
    output logic [HPOS_W-1:0] hb_set,
    output logic [HPOS_W-1:0] hb_rst,
    output logic [LINE_W-1:0] vb_set,
    output logic [LINE_W-1:0] vb_rst,
    output logic [Y_W-1:0]    pan_y,
    output logic [NIB_W-1:0]  pan_u,
    output logic [NIB_W-1:0]  pan_v
);

    localparam int CRS_W    = HPOS_W - 2;
    localparam int FINE_LSB = DW - 2;
    localparam int N_EDGE   = 2;

    logic [CRS_W-1:0] edge_crs [N_EDGE];
    logic [1:0]       edge_fin [N_EDGE];
    logic [HPOS_W-1:0] edge_pos [N_EDGE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_EDGE; i++) begin
                edge_crs[i] <= '0;
                edge_fin[i] <= '0;
            end
            hb_set <= '0;
            hb_rst <= '0;
            vb_set <= '0;
            vb_rst <= '0;
            pan_y  <= '0;
            pan_u  <= '0;
            pan_v  <= '0;
        end else if (wr_en) begin
            case (reg_addr_t'(wr_addr))
                REG_PAN_START: begin
                    edge_crs[0] <= wr_data[CRS_W-1:0];
                    edge_fin[0] <= wr_data[FINE_LSB +: 2];
                end
                REG_PAN_STOP: begin
                    edge_crs[1] <= wr_data[CRS_W-1:0];
                    edge_fin[1] <= wr_data[FINE_LSB +: 2];
                end
                REG_HB_SET:    hb_set <= wr_data[HPOS_W-1:0];
                REG_HB_RST:    hb_rst <= wr_data[HPOS_W-1:0];
                REG_VB_SET:    vb_set <= wr_data[LINE_W-1:0];
                REG_VB_RST:    vb_rst <= wr_data[LINE_W-1:0];
                REG_PAN_LUMA:  pan_y  <= wr_data[Y_W-1:0];
                REG_PAN_CHROM: begin
                    pan_u <= wr_data[NIB_W-1:0];
                    pan_v <= wr_data[2*NIB_W-1:NIB_W];
                end
                default: ;
            endcase
        end
    end

    // Effective edge = coarse * 4 + fine
    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        assign edge_pos[g] = {edge_crs[g], 2'b00} + HPOS_W'(edge_fin[g]);
    end

    assign pan_start = edge_pos[0];
    assign pan_stop  = edge_pos[1];

endmodule

// File: rtl/pbi_tracker.sv
`timescale 1ns/1ps
module pbi_tracker
    import pbi_pkg::*;
#(
    parameter int HPOS_W = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_ref,
    input  logic              v_ref,
    output logic [HPOS_W-1:0] hpos,
    output logic [LINE_W-1:0] line_no,
    output logic              h_ok,
    output logic              v_ok,
    output trk_state_t        state
);

    localparam logic [HPOS_W-1:0] HMAX = '1;
    localparam logic [LINE_W-1:0] LMAX = '1;

    logic              h_q;
    logic              v_q;
    logic              h_rise;
    logic              v_rise;
    logic [HPOS_W-1:0] hcnt;
    logic [LINE_W-1:0] lcnt;
    trk_state_t        state_n;

    assign h_rise = h_ref & ~h_q;
    assign v_rise = v_ref & ~v_q;

    // Position of the current sample
    always_comb begin
        if (h_rise)
            hpos = '0;
        else if (hcnt == HMAX)
            hpos = HMAX;
        else
            hpos = hcnt + 1'b1;
    end

    // Line of the current sample; frame edge wins over line edge
    always_comb begin
        if (v_rise)
            line_no = '0;
        else if (h_rise && lcnt != LMAX)
            line_no = lcnt + 1'b1;
        else
            line_no = lcnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q  <= 1'b0;
            v_q  <= 1'b0;
            hcnt <= '0;
            lcnt <= '0;
        end else begin
            h_q  <= h_ref;
            v_q  <= v_ref;
            hcnt <= hpos;
            lcnt <= line_no;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TRK_IDLE;
        else
            state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            TRK_IDLE: begin
                if (h_rise && v_rise)
                    state_n = TRK_FULL;
                else if (h_rise)
                    state_n = TRK_HLOCK;
                else if (v_rise)
                    state_n = TRK_VLOCK;
            end
            TRK_HLOCK: if (v_rise) state_n = TRK_FULL;
            TRK_VLOCK: if (h_rise) state_n = TRK_FULL;
            TRK_FULL:  state_n = TRK_FULL;
            default:   state_n = TRK_IDLE;
        endcase
    end

    // Output decode of the state being entered, so the edge sample counts
    always_comb begin
        h_ok = 1'b0;
        v_ok = 1'b0;
        unique case (state_n)
            TRK_IDLE:  ;
            TRK_HLOCK: h_ok = 1'b1;
            TRK_VLOCK: v_ok = 1'b1;
            TRK_FULL: begin
                h_ok = 1'b1;
                v_ok = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbi_window.sv
`timescale 1ns/1ps
module pbi_window #(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         act
);

    // Half-open interval [lo, hi); empty when lo >= hi
    assign act = (pos >= lo) && (pos < hi);

endmodule

// File: rtl/pbi_mixer.sv
`timescale 1ns/1ps
module pbi_mixer
    import pbi_pkg::*;
#(
    parameter int Y_W     = 10,
    parameter int C_W     = 8,
    parameter int NIB_W   = 4,
    parameter int BLANK_Y = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic             panel,
    input  logic [Y_W-1:0]   y_in,
    input  logic [C_W-1:0]   u_in,
    input  logic [C_W-1:0]   v_in,
    input  logic [Y_W-1:0]   pan_y,
    input  logic [NIB_W-1:0] pan_u,
    input  logic [NIB_W-1:0] pan_v,
    output logic [Y_W-1:0]   y_out,
    output logic [C_W-1:0]   u_out,
    output logic [C_W-1:0]   v_out
);

    localparam int LOW_W = C_W - NIB_W;

    mix_sel_t       sel;
    logic [Y_W-1:0] y_nx;
    logic [C_W-1:0] u_nx;
    logic [C_W-1:0] v_nx;

    always_comb begin
        if (blank)
            sel = SEL_BLANK;
        else if (panel)
            sel = SEL_PANEL;
        else
            sel = SEL_PASS;
    end

    always_comb begin
        y_nx = y_in;
        u_nx = u_in;
        v_nx = v_in;
        unique case (sel)
            SEL_PASS: ;
            SEL_PANEL: begin
                y_nx = pan_y;
                u_nx = {pan_u, {LOW_W{1'b0}}};
                v_nx = {pan_v, {LOW_W{1'b0}}};
            end
            SEL_BLANK: begin
                y_nx = Y_W'(BLANK_Y);
                u_nx = '0;
                v_nx = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out <= '0;
            u_out <= '0;
            v_out <= '0;
        end else begin
            y_out <= y_nx;
            u_out <= u_nx;
            v_out <= v_nx;
        end
    end

endmodule

// File: rtl/panel_blank_inserter.sv
`timescale 1ns/1ps
module panel_blank_inserter
    import pbi_pkg::*;
#(
    parameter int HPOS_W  = 12,
    parameter int LINE_W  = 11,
    parameter int Y_W     = 10,
    parameter int C_W     = 8,
    parameter int NIB_W   = 4,
    parameter int DW      = 14,
    parameter int BLANK_Y = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              h_ref,
    input  logic              v_ref,
    input  logic [Y_W-1:0]    y_in,
    input  logic [C_W-1:0]    u_in,
    input  logic [C_W-1:0]    v_in,
    output logic [Y_W-1:0]    y_out,
    output logic [C_W-1:0]    u_out,
    output logic [C_W-1:0]    v_out
);

    localparam int N_HWIN = 2;   // 0: sidepanel, 1: horizontal blank

    logic [HPOS_W-1:0] pan_start, pan_stop, hb_set, hb_rst;
    logic [LINE_W-1:0] vb_set, vb_rst;
    logic [Y_W-1:0]    pan_y;
    logic [NIB_W-1:0]  pan_u, pan_v;

    logic [HPOS_W-1:0] hpos;
    logic [LINE_W-1:0] line_no;
    logic              h_ok, v_ok;
    trk_state_t        trk_state;

    logic [HPOS_W-1:0] hw_lo [N_HWIN];
    logic [HPOS_W-1:0] hw_hi [N_HWIN];
    logic [N_HWIN-1:0] hw_act;
    logic              vw_act;

    logic              panel_c, hb_act, vb_act, blank_c;

    pbi_regs #(
        .HPOS_W(HPOS_W), .LINE_W(LINE_W), .Y_W(Y_W), .NIB_W(NIB_W), .DW(DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pan_start (pan_start),
        .pan_stop  (pan_stop),
        .hb_set    (hb_set),
        .hb_rst    (hb_rst),
        .vb_set    (vb_set),
        .vb_rst    (vb_rst),
        .pan_y     (pan_y),
        .pan_u     (pan_u),
        .pan_v     (pan_v)
    );

    pbi_tracker #(
        .HPOS_W(HPOS_W), .LINE_W(LINE_W)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_ref   (h_ref),
        .v_ref   (v_ref),
        .hpos    (hpos),
        .line_no (line_no),
        .h_ok    (h_ok),
        .v_ok    (v_ok),
        .state   (trk_state)
    );

    assign hw_lo[0] = pan_start;
    assign hw_hi[0] = pan_stop;
    assign hw_lo[1] = hb_set;
    assign hw_hi[1] = hb_rst;

    for (genvar g = 0; g < N_HWIN; g++) begin : g_hwin
        pbi_window #(.W(HPOS_W)) u_win (
            .pos (hpos),
            .lo  (hw_lo[g]),
            .hi  (hw_hi[g]),
            .act (hw_act[g])
        );
    end

    pbi_window #(.W(LINE_W)) u_vwin (
        .pos (line_no),
        .lo  (vb_set),
        .hi  (vb_rst),
        .act (vw_act)
    );

    assign panel_c = hw_act[0] & h_ok;
    assign hb_act  = hw_act[1] & h_ok;
    assign vb_act  = vw_act & v_ok;
    assign blank_c = hb_act | vb_act;

    pbi_mixer #(
        .Y_W(Y_W), .C_W(C_W), .NIB_W(NIB_W), .BLANK_Y(BLANK_Y)
    ) u_mix (
        .clk   (clk),
        .rst_n (rst_n),
        .blank (blank_c),
        .panel (panel_c),
        .y_in  (y_in),
        .u_in  (u_in),
        .v_in  (v_in),
        .pan_y (pan_y),
        .pan_u (pan_u),
        .pan_v (pan_v),
        .y_out (y_out),
        .u_out (u_out),
        .v_out (v_out)
    );

endmodule

// File: rtl/pbi_checker.sv
`timescale 1ns/1ps
module pbi_checker
    import pbi_pkg::*;
#(
    parameter int HPOS_W  = 12,
    parameter int LINE_W  = 11,
    parameter int Y_W     = 10,
    parameter int C_W     = 8,
    parameter int NIB_W   = 4,
    parameter int BLANK_Y = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_ref,
    input logic              v_ref,
    input logic [Y_W-1:0]    y_in,
    input logic [C_W-1:0]    u_in,
    input logic [C_W-1:0]    v_in,
    input logic [Y_W-1:0]    y_out,
    input logic [C_W-1:0]    u_out,
    input logic [C_W-1:0]    v_out,
    input logic [HPOS_W-1:0] hpos,
    input logic [LINE_W-1:0] line_no,
    input logic              panel_c,
    input logic              hb_act,
    input logic              vb_act,
    input logic [Y_W-1:0]    pan_y,
    input logic [NIB_W-1:0]  pan_u,
    input logic [NIB_W-1:0]  pan_v,
    input trk_state_t        trk_state
);

    localparam int LOW_W = C_W - NIB_W;

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!panel_c && !hb_act && !vb_act) |=>
        (y_out == $past(y_in) && u_out == $past(u_in) && v_out == $past(v_in)));

    // R5 R6
    blank_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_act || vb_act) |=>
        (y_out == Y_W'(BLANK_Y) && u_out == '0 && v_out == '0));

    // R4 R10
    panel_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (panel_c && !hb_act && !vb_act) |=>
        (y_out == $past(pan_y) &&
         u_out == {$past(pan_u), {LOW_W{1'b0}}} &&
         v_out == {$past(pan_v), {LOW_W{1'b0}}}));

    // R2
    hpos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ref && !$past(h_ref)) |-> (hpos == '0));

    // R8
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_ref && !$past(v_ref)) |-> (line_no == '0));

    // R11
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_state == TRK_IDLE && !h_ref && !v_ref) |->
        (!panel_c && !hb_act && !vb_act));

endmodule

bind panel_blank_inserter pbi_checker #(
    .HPOS_W(HPOS_W), .LINE_W(LINE_W), .Y_W(Y_W), .C_W(C_W),
    .NIB_W(NIB_W), .BLANK_Y(BLANK_Y)
) u_pbi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_ref     (h_ref),
    .v_ref     (v_ref),
    .y_in      (y_in),
    .u_in      (u_in),
    .v_in      (v_in),
    .y_out     (y_out),
    .u_out     (u_out),
    .v_out     (v_out),
    .hpos      (hpos),
    .line_no   (line_no),
    .panel_c   (panel_c),
    .hb_act    (hb_act),
    .vb_act    (vb_act),
    .pan_y     (pan_y),
    .pan_u     (pan_u),
    .pan_v     (pan_v),
    .trk_state (trk_state)
);

// File: tb/panel_blank_inserter_bench.sv
`timescale 1ns/1ps
module panel_blank_inserter_bench;

    localparam int HMAX = 4095;
    localparam int LMAX = 2047;

    typedef struct packed {
        logic [9:0]  sc;   // panel start coarse
        logic [1:0]  sf;   // panel start fine
        logic [9:0]  ec;   // panel stop coarse
        logic [1:0]  ef;   // panel stop fine
        logic [11:0] hs;   // h blank set
        logic [11:0] hr;   // h blank reset
        logic [10:0] vs;   // v blank set line
        logic [10:0] vr;   // v blank reset line
        logic [9:0]  py;   // panel luma
        logic [3:0]  pu;   // panel U nibble
        logic [3:0]  pv;   // panel V nibble
    } cfg_t;

    // Stimulus/expectation table: each row is a window set, walked over
    // idle samples, one unlocked line and two frames of five lines.
    // Row 1: zero-length hblank and vblank (R9, start==stop), panel at 0..1.
    // Row 2: hblank inside panel (R10). Row 3: panel start > stop (R9).
    localparam cfg_t CFGS [4] = '{
        '{10'd2,  2'd1, 10'd5,  2'd3, 12'd60, 12'd70, 11'd1, 11'd3, 10'h2A5, 4'h9, 4'h3},
        '{10'd0,  2'd0, 10'd0,  2'd2, 12'd0,  12'd0,  11'd0, 11'd0, 10'h3FF, 4'hF, 4'h0},
        '{10'd3,  2'd0, 10'd15, 2'd0, 12'd20, 12'd30, 11'd4, 11'd9, 10'h100, 4'h5, 4'hA},
        '{10'd10, 2'd0, 10'd5,  2'd0, 12'd75, 12'd90, 11'd2, 11'd2, 10'h055, 4'h1, 4'h2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        h_ref = 1'b0;
    logic        v_ref = 1'b0;
    logic [9:0]  y_in = '0;
    logic [7:0]  u_in = '0;
    logic [7:0]  v_in = '0;
    logic [9:0]  y_out;
    logic [7:0]  u_out;
    logic [7:0]  v_out;

    always #2.5 clk = ~clk;

    panel_blank_inserter u_panel_blank_inserter (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .h_ref   (h_ref),
        .v_ref   (v_ref),
        .y_in    (y_in),
        .u_in    (u_in),
        .v_in    (v_in),
        .y_out   (y_out),
        .u_out   (u_out),
        .v_out   (v_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int seed    = 0;

    // bench model
    logic m_prev_h, m_prev_v, m_hseen, m_vseen;
    int   m_hp, m_ln;
    int   m_ps, m_pe, m_hs, m_hr, m_vs, m_vr;
    logic [9:0] m_py;
    logic [3:0] m_pu, m_pv;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit check_zero);
        @(negedge clk);
        rst_n = 1'b0;
        h_ref = 1'b0; v_ref = 1'b0; wr_en = 1'b0;
        y_in = 10'h155; u_in = 8'h5A; v_in = 8'hA5;
        repeat (3) @(negedge clk);
        if (check_zero) begin
            // R1: reset state of the outputs
            chk("R1 reset y_out", 32'(y_out), 32'd0);
            chk("R1 reset u_out", 32'(u_out), 32'd0);
            chk("R1 reset v_out", 32'(v_out), 32'd0);
        end
        rst_n = 1'b1;
        m_prev_h = 1'b0; m_prev_v = 1'b0;
        m_hseen = 1'b0; m_vseen = 1'b0;
        m_hp = 0; m_ln = 0;
    endtask

    // R12: one write, effective from the next clock
    task automatic wr(input logic [2:0] a, input logic [13:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input cfg_t c);
        // R3: coarse in [9:0], fine in [13:12]
        wr(3'd0, {c.sf, 2'b00, c.sc});
        wr(3'd1, {c.ef, 2'b00, c.ec});
        wr(3'd2, 14'(c.hs));
        wr(3'd3, 14'(c.hr));
        wr(3'd4, 14'(c.vs));
        wr(3'd5, 14'(c.vr));
        wr(3'd6, 14'(c.py));
        wr(3'd7, 14'({c.pv, c.pu}));
        m_ps = int'(c.sc) * 4 + int'(c.sf);
        m_pe = int'(c.ec) * 4 + int'(c.ef);
        m_hs = int'(c.hs); m_hr = int'(c.hr);
        m_vs = int'(c.vs); m_vr = int'(c.vr);
        m_py = c.py; m_pu = c.pu; m_pv = c.pv;
    endtask

    // Drive one sample at a falling edge, check it one clock later.
    task automatic pix(input logic h, input logic a);
        logic [9:0]  y;
        logic [7:0]  u, v;
        logic        rh, rv, hb, vb, pn;
        logic [25:0] exp_v;
        string       tag;
        y = 10'(seed * 37 + 11);
        u = 8'(seed * 13 + 3);
        v = 8'(seed * 29 + 7);
        seed++;
        h_ref = h; v_ref = a; y_in = y; u_in = u; v_in = v;
        rh = h && !m_prev_h;
        rv = a && !m_prev_v;
        m_prev_h = h; m_prev_v = a;
        // R2: position 0 on the line edge, then +1, saturating
        if (rh) begin m_hp = 0; m_hseen = 1'b1; end
        else if (m_hp != HMAX) m_hp++;
        // R8: frame edge gives line 0 and wins; line edge adds one
        if (rv) begin m_ln = 0; m_vseen = 1'b1; end
        else if (rh && m_ln != LMAX) m_ln++;
        // R7 R8 R9 R11: half-open windows gated by lock
        hb = m_hseen && (m_hp >= m_hs) && (m_hp < m_hr);
        vb = m_vseen && (m_ln >= m_vs) && (m_ln < m_vr);
        pn = m_hseen && (m_hp >= m_ps) && (m_hp < m_pe);
        if (hb || vb) exp_v = {10'd64, 8'd0, 8'd0};          // R5 R6
        else if (pn)  exp_v = {m_py, m_pu, 4'd0, m_pv, 4'd0}; // R4
        else          exp_v = {y, u, v};                      // R1
        if ((hb || vb) && pn) tag = "R10 R6";
        else if (vb)          tag = "R8 R6";
        else if (hb)          tag = "R7 R5";
        else if (pn)          tag = "R3 R4";
        else if (!m_hseen)    tag = "R11";
        else                  tag = "R1 R2";
        @(negedge clk);
        chk(tag, 32'({y_out, u_out, v_out}), 32'(exp_v));
    endtask

    task automatic run_line(input int len, input bit with_h, input int v_at);
        for (int p = 0; p < len; p++)
            pix(with_h && p < 4, v_at >= 0 && p >= v_at && p < v_at + 6);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        cfg_t dc;

        // Directed: reset state
        do_reset(1'b1);

        // Table walk
        for (int i = 0; i < 4; i++) begin
            do_reset(1'b0);
            load(CFGS[i]);
            repeat (6) pix(1'b0, 1'b0);         // R11: no reference yet
            run_line(80, 1'b1, -1);             // line lock only
            for (int f = 0; f < 2; f++)
                for (int l = 0; l < 5; l++)
                    run_line(80, 1'b1, (l == 0) ? ((f == 0) ? 0 : 10) : -1);
        end

        // Directed: frame edge alone first (VLOCK), then line edge (R11 R8)
        do_reset(1'b0);
        dc = '{10'd1000, 2'd0, 10'd0, 2'd0, 12'd0, 12'd0, 11'd0, 11'd1, 10'h1C0, 4'h6, 4'h9};
        dc.ec = 10'd1000; dc.sc = 10'd0;
        load(dc);
        repeat (5) pix(1'b0, 1'b0);
        run_line(20, 1'b0, 0);
        run_line(30, 1'b1, -1);

        // Directed: position saturation with a blank at 4094 only (R2)
        do_reset(1'b0);
        dc = '{10'd0, 2'd0, 10'd0, 2'd0, 12'd4094, 12'd4095, 11'd0, 11'd0, 10'h2, 4'h1, 4'h1};
        load(dc);
        run_line(4200, 1'b1, -1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule